// File: doc/BRIEF.md
# Rotating Windowed Register File

This block is a processor integer register file whose architectural view is a window of 32 registers sliding over a larger physical array. The physical array holds eight global registers and, for each of `NWIN` windows, a private bank of sixteen registers. The window pointer moves one step forward on a save command and one step back on a restore command. The pointer wraps around modulo `NWIN`, so the windows form a ring and call nesting has no fixed limit. Adjacent windows overlap. The eight output registers of one window are the eight input registers of the window after it, which lets a caller pass arguments to a callee without copying them.

The block has two combinational read ports and one write port. A save or restore issued in the same cycle as a write takes its operands through the old window and writes its result through the new one. An occupancy counter tracks how many windows hold live frames. The block raises an overflow trap when a save would run into the oldest live frame and an underflow trap when a restore finds no saved frame. The trap handlers sit outside the block. The occupancy update made in the trapping cycle stands in for their spill or fill, so the same command succeeds when it is issued again.

Top module: `regwin_file`

## Requirements
- R1: Architectural register 0 always reads as zero on both read ports, and a write addressed to it changes no register.
- R2: Architectural indices 0..7 select global registers that are shared by every window. Indices 8..15 (outs) and 16..23 (locals) select registers private to the current window `cwp`. Indices 24..31 (ins) select the same physical registers as the outs of window (`cwp`-1) mod `NWIN`.
- R3: Command code 2'b00 is idle and code 2'b11 is also treated as idle. With an idle command `cwp` keeps its value and a write goes to the current window.
- R4: A save (command 2'b01) that does not trap sets `cwp` to (`cwp`+1) mod `NWIN` on the next clock edge and increments the occupancy count.
- R5: A restore (command 2'b10) that does not trap sets `cwp` to (`cwp`-1) mod `NWIN` on the next clock edge and decrements the occupancy count.
- R6: In the cycle of a save or restore that does not trap, both read ports decode through the old window and the write port decodes through the new window.
- R7: A save issued when the occupancy count equals `NWIN`-1 drives `ovf_trap` high in that cycle. It leaves `cwp` unchanged, suppresses the write and lowers the count by one, so the save succeeds when it is issued again.
- R8: A restore issued when the occupancy count is 0 drives `unf_trap` high in that cycle. It leaves `cwp` unchanged, suppresses the write and raises the count by one, so the restore succeeds when it is issued again.
- R9: Reads are combinational and return the value held before the current clock edge. A write becomes visible from the following cycle.
- R10: After reset `cwp` and the occupancy count are 0, both traps are low and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 2 | Window command: 00 idle, 01 save, 10 restore, 11 idle |
| rd_addr_a | input | 5 | Architectural index for read port A |
| rd_data_a | output | DW | Read port A data |
| rd_addr_b | input | 5 | Architectural index for read port B |
| rd_data_b | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural index for the write |
| wr_data | input | DW | Write data |
| cwp | output | WW | Current window pointer |
| ovf_trap | output | 1 | Window overflow trap, same cycle as the save |
| unf_trap | output | 1 | Window underflow trap, same cycle as the restore |

## Verification
The bench builds the block with `NWIN` = 4 and `DW` = 16. Four windows are few enough that random save and restore traffic fills the ring often. The traffic therefore takes the pointer across the wrap from the last window back to window 0, where the ins of window 0 alias the outs of window 3. The same small count makes overflow and underflow frequent, so retried commands after a trap are exercised many times. Directed steps cover the output-to-input hand-over across a save, a write to register 0, and a read of a register in the same cycle as a write to it.

// File: rtl/rwin_pkg.sv
// Shared constants and the command encoding for the windowed register file.
// Assumes a 32-entry architectural view split into four banks of eight.
package rwin_pkg;
    localparam int ARCH_AW   = 5;
    localparam int BANK_SIZE = 8;
    localparam int WIN_SPAN  = 2 * BANK_SIZE;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'b00,
        CMD_SAVE    = 2'b01,
        CMD_RESTORE = 2'b10,
        CMD_NOP     = 2'b11
    } win_cmd_e;
endpackage

// File: rtl/rwin_map.sv
// Maps an architectural register index within a window to a physical index.
// Physical layout: globals at 0..7, then for each window w a 16-entry bank
// starting at 8+16*w (outs first, then locals). Ins of window w are the outs
// of window (w-1) mod NWIN. Purely combinational.
module rwin_map #(
    parameter int NWIN = 8,
    parameter int WW   = 3,
    parameter int PW   = 8
) (
    input  logic [rwin_pkg::ARCH_AW-1:0] arch,
    input  logic [WW-1:0]                win,
    output logic [PW-1:0]                phys
);
    import rwin_pkg::*;

    // Select the bank and add the offset within it.
    always_comb begin
        int w_cur;
        int w_prv;
        int idx;
        w_cur = int'(win);
        w_prv = (w_cur == 0) ? NWIN - 1 : w_cur - 1;
        case (arch[4:3])
            2'd0:    idx = int'(arch);
            2'd1:    idx = BANK_SIZE + WIN_SPAN * w_cur + int'(arch[2:0]);
            2'd2:    idx = 2 * BANK_SIZE + WIN_SPAN * w_cur + int'(arch[2:0]);
            default: idx = BANK_SIZE + WIN_SPAN * w_prv + int'(arch[2:0]);
        endcase
        phys = PW'(idx);
    end
endmodule

// File: rtl/rwin_ctrl.sv
// Window pointer and occupancy control. Decodes the command and decides the
// trap outputs, the window the write port targets, and whether the write may
// proceed. A trapped command keeps the pointer and adjusts occupancy in place
// of the spill or fill a handler would perform.
module rwin_ctrl #(
    parameter int NWIN = 8,
    parameter int WW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cmd,
    output logic [WW-1:0] cwp,
    output logic [WW-1:0] wr_win,
    output logic          wr_ok,
    output logic          ovf,
    output logic          unf
);
    import rwin_pkg::*;

    localparam logic [WW-1:0] LAST = WW'(NWIN - 1);

    logic [WW-1:0] depth;
    logic [WW-1:0] nxt_win;
    logic [WW-1:0] prv_win;
    logic          is_save;
    logic          is_rest;

    // Decode the command and derive traps and the write target window.
    always_comb begin
        is_save = (cmd == CMD_SAVE);
        is_rest = (cmd == CMD_RESTORE);
        nxt_win = (cwp == LAST) ? '0 : cwp + 1'b1;
        prv_win = (cwp == '0) ? LAST : cwp - 1'b1;
        ovf     = is_save && (depth == LAST);
        unf     = is_rest && (depth == '0);
        wr_ok   = !(ovf || unf);
        if (is_save && !ovf)      wr_win = nxt_win;
        else if (is_rest && !unf) wr_win = prv_win;
        else                      wr_win = cwp;
    end

    // Advance the pointer and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp   <= '0;
            depth <= '0;
        end else if (ovf) begin
            depth <= depth - 1'b1;
        end else if (unf) begin
            depth <= depth + 1'b1;
        end else if (is_save) begin
            cwp   <= nxt_win;
            depth <= depth + 1'b1;
        end else if (is_rest) begin
            cwp   <= prv_win;
            depth <= depth - 1'b1;
        end
    end
endmodule

// File: rtl/rwin_store.sv
// Physical register array with two asynchronous read ports and one
// synchronous write port. Assumes addresses are below NPHYS.
module rwin_store #(
    parameter int NPHYS = 136,
    parameter int PW    = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [PW-1:0] ra_a,
    input  logic [PW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);
    logic [DW-1:0] mem [NPHYS];

    // Clear on reset, otherwise perform the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_a = mem[ra_a];
        rd_b = mem[ra_b];
    end
endmodule

// File: rtl/regwin_file.sv
// Top of the windowed register file. Reads decode through the current window.
// The write decodes through the window selected by the command. Register 0
// is forced to zero on reads and never written.
module regwin_file #(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  cmd,
    input  logic [4:0]                  rd_addr_a,
    output logic [DW-1:0]               rd_data_a,
    input  logic [4:0]                  rd_addr_b,
    output logic [DW-1:0]               rd_data_b,
    input  logic                        wr_en,
    input  logic [4:0]                  wr_addr,
    input  logic [DW-1:0]               wr_data,
    output logic [((NWIN > 1) ? $clog2(NWIN) : 1)-1:0] cwp,
    output logic                        ovf_trap,
    output logic                        unf_trap
);
    localparam int WW    = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int NPHYS = rwin_pkg::BANK_SIZE + rwin_pkg::WIN_SPAN * NWIN;
    localparam int PW    = $clog2(NPHYS);

    logic [WW-1:0] wr_win;
    logic          wr_ok;
    logic [PW-1:0] pa;
    logic [PW-1:0] pb;
    logic [PW-1:0] pw;
    logic [DW-1:0] st_a;
    logic [DW-1:0] st_b;
    logic          we;

    rwin_ctrl #(.NWIN(NWIN), .WW(WW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cwp(cwp),
        .wr_win(wr_win), .wr_ok(wr_ok), .ovf(ovf_trap), .unf(unf_trap)
    );

    rwin_map #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_map_a (
        .arch(rd_addr_a), .win(cwp), .phys(pa)
    );
    rwin_map #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_map_b (
        .arch(rd_addr_b), .win(cwp), .phys(pb)
    );
    rwin_map #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_map_w (
        .arch(wr_addr), .win(wr_win), .phys(pw)
    );

    // Gate the write: no trap and not register 0.
    always_comb we = wr_en && wr_ok && (wr_addr != '0);

    rwin_store #(.NPHYS(NPHYS), .PW(PW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .wa(pw), .wd(wr_data),
        .ra_a(pa), .ra_b(pb), .rd_a(st_a), .rd_b(st_b)
    );

    // Force register 0 to read as zero.
    always_comb begin
        rd_data_a = (rd_addr_a == '0) ? '0 : st_a;
        rd_data_b = (rd_addr_b == '0) ? '0 : st_b;
    end
endmodule

// File: rtl/rwin_checker.sv
// Protocol checks on the ports of regwin_file, attached by bind.
module rwin_checker #(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    parameter int WW   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cmd,
    input logic [4:0]    rd_addr_a,
    input logic [DW-1:0] rd_data_a,
    input logic [4:0]    rd_addr_b,
    input logic [DW-1:0] rd_data_b,
    input logic [WW-1:0] cwp,
    input logic          ovf_trap,
    input logic          unf_trap
);
    localparam logic [WW-1:0] LAST = WW'(NWIN - 1);

    a_r1_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == 5'd0) |-> (rd_data_a == '0));
    a_r1_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == 5'd0) |-> (rd_data_b == '0));
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b00 || cmd == 2'b11) |=> $stable(cwp));
    a_r4_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && !ovf_trap) |=>
        (cwp == (($past(cwp) == LAST) ? '0 : $past(cwp) + 1'b1)));
    a_r5_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b10 && !unf_trap) |=>
        (cwp == (($past(cwp) == '0) ? LAST : $past(cwp) - 1'b1)));
    a_r7_overflow_on_save: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> (cmd == 2'b01));
    a_r7_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |=> $stable(cwp));
    a_r8_underflow_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> (cmd == 2'b10));
    a_r8_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |=> $stable(cwp));
endmodule

bind regwin_file rwin_checker #(.NWIN(NWIN), .DW(DW), .WW(WW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
);

// File: tb/test_regwin_file.sv
`timescale 1ns/1ps
// Bench for regwin_file: directed corners plus seeded random traffic,
// compared against a behavioural model kept in the bench.
module test_regwin_file;
    localparam int N     = 4;
    localparam int DW    = 16;
    localparam int WW    = 2;
    localparam int NPHYS = 8 + 16 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic [4:0]    rd_addr_a = '0;
    logic [4:0]    rd_addr_b = '0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [WW-1:0] cwp;
    logic          ovf_trap;
    logic          unf_trap;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_reg [NPHYS];
    int m_cwp = 0;
    int m_depth = 0;

    always #4 clk = ~clk;

    regwin_file #(.NWIN(N), .DW(DW)) i_regwin_file (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    // Physical slot of an architectural index in window w (R2).
    function automatic int slot(input int a, input int w);
        int off = a % 8;
        if (a < 8)  return a;
        if (a < 16) return 8 + 16 * w + off;
        if (a < 24) return 16 + 16 * w + off;
        return 8 + 16 * ((w + N - 1) % N) + off;
    endfunction

    function automatic logic [DW-1:0] exp_rd(input int a);
        return (a == 0) ? '0 : m_reg[slot(a, m_cwp)];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, compare in mid-cycle, then advance the model at the edge.
    task automatic step(input logic [1:0] c, input bit we, input int wa,
                        input int wd, input int ra, input int rb, input string req);
        bit e_ovf, e_unf, sv, rs;
        int tgt;
        cmd = c; wr_en = we; wr_addr = 5'(wa); wr_data = DW'(wd);
        rd_addr_a = 5'(ra); rd_addr_b = 5'(rb);
        #1;
        sv = (c == 2'b01); rs = (c == 2'b10);
        e_ovf = sv && (m_depth == N - 1);
        e_unf = rs && (m_depth == 0);
        check(rd_data_a == exp_rd(ra), req, "rd_data_a", int'(rd_data_a), int'(exp_rd(ra)));
        check(rd_data_b == exp_rd(rb), req, "rd_data_b", int'(rd_data_b), int'(exp_rd(rb)));
        check(int'(cwp) == m_cwp, req, "cwp", int'(cwp), m_cwp);
        check(ovf_trap == e_ovf && unf_trap == e_unf, req, "traps",
              int'({ovf_trap, unf_trap}), int'({e_ovf, e_unf}));
        @(posedge clk);
        tgt = m_cwp;
        if (e_ovf)      m_depth--;
        else if (e_unf) m_depth++;
        else if (sv) begin tgt = (m_cwp + 1) % N; m_depth++; end
        else if (rs) begin tgt = (m_cwp + N - 1) % N; m_depth--; end
        if (we && !e_ovf && !e_unf && wa != 0) m_reg[slot(wa, tgt)] = DW'(wd);
        m_cwp = tgt;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NPHYS; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        step(2'b00, 0, 0, 0, 9, 31, "R10");
        check(cwp == '0, "R10", "cwp after reset", int'(cwp), 0);
        // R1: write to register 0 has no effect
        step(2'b00, 1, 0, 16'hBEEF, 0, 0, "R1");
        step(2'b00, 0, 0, 0, 0, 0, "R1");
        // R9: same-cycle read returns old value, next cycle the new one
        step(2'b00, 1, 9, 16'h1234, 9, 3, "R9");
        check(rd_data_a == 16'h1234, "R9", "write visible next cycle", int'(rd_data_a), 16'h1234);
        step(2'b00, 1, 3, 16'h0303, 9, 3, "R9");
        // R8: restore with nothing saved traps, then retry succeeds
        step(2'b10, 1, 16, 16'h7777, 9, 16, "R8");
        step(2'b10, 0, 0, 0, 9, 16, "R8");
        check(cwp == WW'(N - 1), "R8", "retried restore wraps", int'(cwp), N - 1);
        // R4: save back to window 0, R6 write lands in new window
        step(2'b01, 1, 17, 16'h5151, 25, 17, "R6");
        step(2'b00, 0, 0, 0, 17, 9, "R6");
        check(rd_data_a == 16'h5151, "R6", "write in new window", int'(rd_data_a), 16'h5151);
        // R2: outs of window 0 appear as ins of window 1
        step(2'b01, 0, 0, 0, 25, 3, "R4");
        check(rd_data_a == 16'h1234, "R2", "outs become ins", int'(rd_data_a), 16'h1234);
        check(rd_data_b == 16'h0303, "R2", "global shared", int'(rd_data_b), 16'h0303);
        // R7: fill the ring until a save traps, then retry
        for (int i = 0; i < 4; i++) step(2'b01, 1, 10, i, 10, 25, "R7");
        // R3: reserved code behaves as idle
        step(2'b11, 1, 20, 16'hA5A5, 20, 0, "R3");
        step(2'b00, 0, 0, 0, 20, 0, "R3");
        // Random traffic
        void'($urandom(32'd20240607));
        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom % 8);
            logic [1:0] c = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : (r < 7) ? 2'b10 : 2'b11;
            step(c, ($urandom % 2) == 1, int'($urandom % 32), int'($urandom % 65536),
                 int'($urandom % 32), int'($urandom % 32), "R2/R4/R5/R6");
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule